// File: doc/BRIEF.md
# Bitplane Conditional-Accumulate Linear Projector

This block forms one linear projection of an image, a dot product between a binned version of the frame and a stored signed weight pattern. It works on a stream of one-bit pixel planes and keeps no frame buffer. Every scan of the focal plane gives one bit per pixel, and each bit is used in the cycle it arrives. A set bit adds the weight of its 5×5 binning cell to the result. Summed over all scans, this equals the weighted sum of the binned multi-bit intensities.

A beat carries five neighbouring pixel bits of one row, together with the row and the column of the first of them. Each bit lane has its own conditional accumulator. A balanced adder tree joins the lanes to give the signed score, which is captured when the frame closes. The 32×24 weight pattern holds 5-bit entries, split across two memory banks by the parity of the cell row. Weights are loaded through a write port that is locked while a frame is open.

Top module: `bitplane_projector`

## Requirements
- R1: After reset, `score` reads 0 and `score_valid` is low.
- R2: `pix_bits[i]` is the pixel at row `pix_row` and column `pix_col`+i. All five lanes of a beat use the weight of cell (`pix_row`/5, `pix_col`/5), written beforehand through `wr_cell_row`/`wr_cell_col`.
- R3: The reported score equals the sum, over all accepted beats of the frame, of popcount(`pix_bits`) × the signed cell weight. The signed width holds 25·S·768·16 with S = `NSCAN`, so it cannot overflow.
- R4: A `frame_start` seen while no frame is open clears the running sum. A frame with no beats reports 0.
- R5: `score_valid` is high for exactly one cycle: the cycle after a `frame_end` sampled while a frame is open. `score` keeps its value until the next such pulse.
- R6: Weight writes are dropped on every cycle from the accepted `frame_start` through the closing `frame_end`, inclusive.
- R7: A beat with `pix_row` ≥ 120 or `pix_col` ≥ 160 adds nothing.
- R8: Weights are 5-bit two's complement. The code 10000 means −16 and 01111 means +15.
- R9: A beat presented in the same cycle as the accepted `frame_start`, or in the same cycle as the closing `frame_end`, is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Opens a frame and clears the sum |
| frame_end | input | 1 | Closes the frame and captures the score |
| pix_valid | input | 1 | Beat qualifier |
| pix_row | input | 7 | Pixel row of the beat |
| pix_col | input | 8 | Pixel column of lane 0 |
| pix_bits | input | 5 | One bit per lane, lane i at column pix_col+i |
| wr_en | input | 1 | Weight write strobe |
| wr_cell_row | input | 5 | Cell row of the weight written |
| wr_cell_col | input | 6 | Cell column of the weight written |
| wr_weight | input | 5 | Weight code, two's complement |
| score | output | 26 | Signed projection result |
| score_valid | output | 1 | One-cycle strobe marking a new score |

## Verification
The bench walks every pixel row and every five-column group over several scans, with pseudo-random bits. Out-of-range beats are mixed into the walk, so a design with a wrong cell division, swapped lanes or a missing range guard gives a sum that differs from the bench's arithmetic. Single-bit frames probe the corners of cell boundaries, and an all −16 pattern over full planes exposes a design that zero-extends weights or sizes the score too narrowly. Writes issued mid-frame, beats on the opening and closing cycles, and an empty frame after a busy one catch an unlocked memory, dropped edge beats and a sum that is not cleared.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

  // Two's-complement value of the low 'width' bits of a raw weight code.
  function automatic int weight_value(input logic [7:0] raw, input int width);
    int mag;
    mag = int'(raw) & ((1 << width) - 1);
    if (mag >= (1 << (width - 1))) return mag - (1 << width);
    return mag;
  endfunction

  // Linear index of a cell inside its parity bank.
  function automatic int bank_index(input int cell_row, input int cell_col, input int cols);
    return (cell_row >> 1) * cols + cell_col;
  endfunction

  // Cell coordinate covering a pixel coordinate.
  function automatic int cell_of(input int pix, input int bin);
    return pix / bin;
  endfunction

endpackage

// File: rtl/weight_store.sv
module weight_store #(
  parameter int CELL_ROWS = 24,
  parameter int CELL_COLS = 32,
  parameter int WGT_W     = 5,
  parameter int CROW_W    = 5,
  parameter int CCOL_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [CROW_W-1:0] wr_row,
  input  logic [CCOL_W-1:0] wr_col,
  input  logic [WGT_W-1:0]  wr_data,
  input  logic [CROW_W-1:0] rd_row,
  input  logic [CCOL_W-1:0] rd_col,
  output logic [WGT_W-1:0]  rd_data
);
  import bpp_pkg::*;

  localparam int BANK_ROWS = (CELL_ROWS + 1) / 2;
  localparam int DEPTH     = BANK_ROWS * CELL_COLS;
  localparam int IDX_W     = $clog2(DEPTH);

  logic             wr_in_range;
  logic             wr_commit;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [WGT_W-1:0] bank_out [2];

  assign wr_in_range = (wr_row < CROW_W'(CELL_ROWS)) && (wr_col < CCOL_W'(CELL_COLS));
  assign wr_commit   = wr_en && !lock && wr_in_range;
  assign wr_idx      = IDX_W'(bank_index(int'(wr_row), int'(wr_col), CELL_COLS));
  assign rd_idx      = IDX_W'(bank_index(int'(rd_row), int'(rd_col), CELL_COLS));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WGT_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_commit && (wr_row[0] == 1'(b))) mem[wr_idx] <= wr_data;
    end
    assign bank_out[b] = mem[rd_idx];
  end

  assign rd_data = bank_out[rd_row[0]];

  // R6: while the lock stays up, the same address reads the same weight
  p_weight_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (lock && $past(lock) && $stable(rd_row) && $stable(rd_col)) |-> $stable(rd_data));

endmodule

// File: rtl/cond_lane.sv
module cond_lane #(
  parameter int ACC_W = 26,
  parameter int WGT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit,
  input  logic [WGT_W-1:0] weight,
  output logic [ACC_W-1:0] acc_nx
);
  import bpp_pkg::*;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] w_ext;

  assign w_ext  = ACC_W'(weight_value(8'(weight), WGT_W));
  assign acc_nx = (clr ? '0 : acc_q) + (hit ? w_ext : '0);

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_nx;
  end

  // R4: a clear with no hit leaves the lane at zero
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> (acc_q == '0));

  // R3: no hit and no clear keeps the partial sum
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hit) |=> $stable(acc_q));

endmodule

// File: rtl/proj_adder_tree.sv
module proj_adder_tree #(
  parameter int N = 5,
  parameter int W = 26
) (
  input  logic [N-1:0][W-1:0] terms,
  output logic [W-1:0]        total
);
  localparam int P = 1 << $clog2(N);

  always_comb begin
    logic [W-1:0] t [P];
    for (int i = 0; i < P; i++) t[i] = (i < N) ? terms[i] : '0;
    for (int step = 1; step < P; step = step * 2) begin
      for (int i = 0; i + step < P; i = i + 2 * step) t[i] = t[i] + t[i + step];
    end
    total = t[0];
  end

endmodule

// File: rtl/bitplane_projector.sv
module bitplane_projector #(
  parameter int CELL_ROWS = 24,
  parameter int CELL_COLS = 32,
  parameter int BIN       = 5,
  parameter int WGT_W     = 5,
  parameter int NSCAN     = 64,
  localparam int PIX_ROWS = CELL_ROWS * BIN,
  localparam int PIX_COLS = CELL_COLS * BIN,
  localparam int ROW_W    = $clog2(PIX_ROWS + 1),
  localparam int COL_W    = $clog2(PIX_COLS + 1),
  localparam int CROW_W   = $clog2(CELL_ROWS + 1),
  localparam int CCOL_W   = $clog2(CELL_COLS + 1),
  localparam int LANES    = BIN,
  localparam int SCORE_W  = $clog2(BIN * BIN * NSCAN * CELL_ROWS * CELL_COLS * (1 << (WGT_W - 1))) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_start,
  input  logic                      frame_end,
  input  logic                      pix_valid,
  input  logic [ROW_W-1:0]          pix_row,
  input  logic [COL_W-1:0]          pix_col,
  input  logic [LANES-1:0]          pix_bits,
  input  logic                      wr_en,
  input  logic [CROW_W-1:0]         wr_cell_row,
  input  logic [CCOL_W-1:0]         wr_cell_col,
  input  logic [WGT_W-1:0]          wr_weight,
  output logic signed [SCORE_W-1:0] score,
  output logic                      score_valid
);
  import bpp_pkg::*;

  logic                          busy_q;
  logic                          start_fire;
  logic                          end_fire;
  logic                          frame_open;
  logic                          in_range;
  logic                          accept;
  logic [CROW_W-1:0]             rd_row;
  logic [CCOL_W-1:0]             rd_col;
  logic [WGT_W-1:0]              cell_weight;
  logic [LANES-1:0][SCORE_W-1:0] lane_nx;
  logic [SCORE_W-1:0]            frame_total;

  // Frame control events
  assign start_fire = frame_start && !busy_q;
  assign end_fire   = frame_end && busy_q;
  assign frame_open = busy_q || start_fire;

  always_ff @(posedge clk) begin
    if (rst)             busy_q <= 1'b0;
    else if (start_fire) busy_q <= 1'b1;
    else if (end_fire)   busy_q <= 1'b0;
  end

  // Beat qualification and cell lookup
  assign in_range = (pix_row < ROW_W'(PIX_ROWS)) && (pix_col < COL_W'(PIX_COLS));
  assign accept   = pix_valid && frame_open && in_range;
  assign rd_row   = CROW_W'(cell_of(int'(pix_row), BIN));
  assign rd_col   = CCOL_W'(cell_of(int'(pix_col), BIN));

  weight_store #(
    .CELL_ROWS(CELL_ROWS), .CELL_COLS(CELL_COLS), .WGT_W(WGT_W),
    .CROW_W(CROW_W), .CCOL_W(CCOL_W)
  ) u_store (
    .clk(clk), .rst(rst), .lock(frame_open),
    .wr_en(wr_en), .wr_row(wr_cell_row), .wr_col(wr_cell_col), .wr_data(wr_weight),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(cell_weight)
  );

  // One conditional accumulator per bit lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cond_lane #(.ACC_W(SCORE_W), .WGT_W(WGT_W)) u_lane (
      .clk(clk), .rst(rst), .clr(start_fire),
      .hit(accept && pix_bits[g]), .weight(cell_weight),
      .acc_nx(lane_nx[g])
    );
  end

  proj_adder_tree #(.N(LANES), .W(SCORE_W)) u_tree (
    .terms(lane_nx), .total(frame_total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      score       <= '0;
      score_valid <= 1'b0;
    end else begin
      score_valid <= end_fire;
      if (end_fire) score <= $signed(frame_total);
    end
  end

  // R5: the strobe never lasts two cycles
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    score_valid |=> !score_valid);

  // R5: the score only moves when a frame closes
  p_score_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !end_fire |=> $stable(score));

endmodule

// File: tb/test_bitplane_projector.sv
module test_bitplane_projector;

  logic              clk = 1'b0;
  logic              rst;
  logic              frame_start, frame_end, pix_valid;
  logic [6:0]        pix_row;
  logic [7:0]        pix_col;
  logic [4:0]        pix_bits;
  logic              wr_en;
  logic [4:0]        wr_cell_row;
  logic [5:0]        wr_cell_col;
  logic [4:0]        wr_weight;
  logic signed [25:0] score;
  logic              score_valid;

  int     n_cmp = 0;
  int     n_bad = 0;
  int     wt [24][32];
  longint expv = 0;
  bit     in_frame = 0;
  bit     done = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  bitplane_projector i_bitplane_projector (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
    .pix_valid(pix_valid), .pix_row(pix_row), .pix_col(pix_col), .pix_bits(pix_bits),
    .wr_en(wr_en), .wr_cell_row(wr_cell_row), .wr_cell_col(wr_cell_col),
    .wr_weight(wr_weight), .score(score), .score_valid(score_valid)
  );

  function automatic int wval(input int r, input int c);
    int v = wt[r][c];
    return (v >= 16) ? v - 32 : v;
  endfunction

  function automatic int ones(input logic [4:0] b);
    int n = 0;
    for (int i = 0; i < 5; i++) n += int'(b[i]);
    return n;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // One cycle of stimulus, applied after a falling edge; model follows the requirements.
  task automatic beat(input bit pv, input int r, input int c, input logic [4:0] b,
                      input bit st, input bit en);
    pix_valid = pv; pix_row = 7'(r); pix_col = 8'(c); pix_bits = b;
    frame_start = st; frame_end = en;
    if (st && !in_frame) begin in_frame = 1; expv = 0; end
    if (wr_en && !in_frame) wt[wr_cell_row][wr_cell_col] = int'(wr_weight);
    if (in_frame && pv && r < 120 && c < 160) expv += ones(b) * wval(r / 5, c / 5);
    if (en && in_frame) in_frame = 0;
    @(negedge clk);
    wr_en = 0; frame_start = 0; frame_end = 0; pix_valid = 0;
  endtask

  task automatic idle();
    beat(0, 0, 0, 5'b0, 0, 0);
  endtask

  task automatic write_w(input int r, input int c, input int v);
    wr_en = 1; wr_cell_row = 5'(r); wr_cell_col = 6'(c); wr_weight = 5'(v);
    idle();
  endtask

  // Close the open frame and check the strobe and the held score (R5).
  task automatic close_frame(input string req);
    longint e;
    beat(0, 0, 0, 5'b0, 0, 1);
    e = expv;
    check({req, " score"}, longint'(score), e);
    check("R5 valid high after close", longint'(score_valid), 1);
    idle();
    check("R5 valid single cycle", longint'(score_valid), 0);
    check("R5 score held", longint'(score), e);
  endtask

  task automatic load_formula();
    for (int r = 0; r < 24; r++)
      for (int c = 0; c < 32; c++) write_w(r, c, (r * 5 + c * 11 + 3) & 31);
  endtask

  initial begin
    rst = 1; frame_start = 0; frame_end = 0; pix_valid = 0;
    pix_row = 0; pix_col = 0; pix_bits = 0;
    wr_en = 0; wr_cell_row = 0; wr_cell_col = 0; wr_weight = 0;
    for (int r = 0; r < 24; r++) for (int c = 0; c < 32; c++) wt[r][c] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset score", longint'(score), 0);
    check("R1 reset valid", longint'(score_valid), 0);

    load_formula();

    // R2: cell mapping at cell boundaries, single-bit frames
    beat(1, 4, 5, 5'b00100, 1, 0);   close_frame("R2 cell(0,1)");
    beat(1, 5, 0, 5'b00001, 1, 0);   close_frame("R2 cell(1,0)");
    beat(1, 119, 155, 5'b10000, 1, 0); close_frame("R2 cell(23,31)");
    beat(1, 9, 14, 5'b01010, 1, 0);  close_frame("R2 cell(1,2)");

    // R3/R7: full sweep over three scans with out-of-range beats mixed in
    beat(0, 0, 0, 5'b0, 1, 0);
    for (int p = 0; p < 3; p++) begin
      for (int r = 0; r < 120; r++) begin
        for (int k = 0; k < 32; k++) begin
          int cb = (p == 1) ? (31 - k) * 5 : k * 5;
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          beat(1, r, cb, lfsr[4:0], 0, 0);
        end
        beat(1, (r % 2) ? 120 + (r % 7) : r, (r % 2) ? 0 : 160 + (r % 5), 5'b11111, 0, 0);
      end
    end
    close_frame("R3 sweep sum");

    // R7: only out-of-range beats
    beat(1, 120, 0, 5'b11111, 1, 0);
    beat(1, 0, 160, 5'b11111, 0, 0);
    beat(1, 127, 255, 5'b11111, 0, 0);
    close_frame("R7 out of range");

    // R4: empty frame after a busy one
    beat(0, 0, 0, 5'b0, 1, 0);
    close_frame("R4 empty frame");

    // R9: beats on the opening and closing cycles
    beat(1, 2, 10, 5'b11011, 1, 0);
    idle();
    beat(1, 7, 20, 5'b01111, 0, 1);
    check("R9 edge beats score", longint'(score), expv);
    check("R9 valid", longint'(score_valid), 1);
    idle();

    // R8: most negative weight everywhere, two full planes of ones
    for (int r = 0; r < 24; r++) for (int c = 0; c < 32; c++) write_w(r, c, 16);
    beat(0, 0, 0, 5'b0, 1, 0);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 120; r++)
        for (int k = 0; k < 32; k++) beat(1, r, k * 5, 5'b11111, 0, 0);
    close_frame("R8 all -16");
    check("R8 closed form", longint'(score), -16 * 25 * 768 * 2);

    write_w(3, 3, 15);
    beat(1, 17, 15, 5'b11111, 1, 0);
    close_frame("R8 +15");
    check("R8 +15 closed form", longint'(score), 75);

    // R6: writes inside a frame are dropped
    write_w(0, 0, 3);
    wr_en = 1; wr_cell_row = 0; wr_cell_col = 0; wr_weight = 5'd15;
    beat(1, 0, 0, 5'b11111, 1, 0);
    wr_en = 1; wr_cell_row = 0; wr_cell_col = 0; wr_weight = 5'd15;
    beat(1, 1, 0, 5'b11111, 0, 0);
    wr_en = 1; wr_cell_row = 0; wr_cell_col = 0; wr_weight = 5'd15;
    beat(0, 0, 0, 5'b0, 0, 1);
    check("R6 locked write score", longint'(score), 30);
    idle();
    beat(1, 0, 0, 5'b11111, 1, 0);
    close_frame("R6 weight kept");
    check("R6 kept closed form", longint'(score), 15);
    write_w(0, 0, 15);
    beat(1, 0, 0, 5'b11111, 1, 0);
    close_frame("R6 idle write applies");
    check("R6 idle closed form", longint'(score), 75);

    // R5: score persists across idle cycles
    repeat (5) idle();
    check("R5 long hold", longint'(score), 75);
    check("R5 valid stays low", longint'(score_valid), 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

endmodule